// File: doc/BRIEF.md
# Multi-Cycle Instruction Control Sequencer

This block is the finite-state controller of a 16-bit processor whose datapath moves every value over one shared bus. The controller decides, cycle by cycle, which single source may drive the bus through a gate enable. It also decides which registers capture the bus, how the program-counter, address and ALU muxes are steered, and when memory is enabled or written. The datapath registers live outside this block. The controller sees only the 4-bit opcode taken from the top of the instruction register and a memory-ready flag.

Every instruction starts with a three-state fetch. In the first state the PC is gated onto the bus into the memory address register while the PC loads its incremented value. In the second state memory is read into the memory data register, waiting for ready. In the third state the fetched word is gated from the MDR into the instruction register. One decode cycle follows, and it picks the execute path from the opcode. ADD retires in one execute cycle. The register load (LDR) and register store (STR) instructions take three execute cycles each. Any other opcode returns to fetch straight after decode.

Top module: `mcs_ctrl_top`

## Requirements
- R1: While reset is held, and for the two clock edges after reset is released, the outputs show the first fetch state. In that state gate_pc, ld_mar and ld_pc are high, pc_sel is 2'b00 (incremented PC), and every other strobe and select is low.
- R2: The fetch read state follows the first fetch state. In it mem_en is high and mem_we is low, and ld_mdr equals mem_ready. The state repeats while mem_ready is low and ends on the cycle in which mem_ready is high.
- R3: The fetch read is followed by one cycle with gate_mdr and ld_ir high. Then comes one decode cycle in which every strobe and select output is low.
- R4: Opcode 4'b0001 (ADD) gives one execute cycle with gate_alu, ld_reg and ld_cc high and alu_pass and sr1_from_src low. The next cycle is the first fetch state.
- R5: Opcode 4'b0110 (LDR) gives three steps. First, one cycle with gate_marmux, ld_mar and marmux_base high (base register plus 6-bit offset). Second, a read state that behaves as in R2. Third, one cycle with gate_mdr, ld_reg and ld_cc high. The first fetch state follows.
- R6: Opcode 4'b0111 (STR) gives three steps. First, one cycle with gate_marmux, ld_mar and marmux_base high. Second, one cycle with gate_alu, ld_mdr, alu_pass and sr1_from_src high. Third, a write state with mem_en and mem_we high that repeats while mem_ready is low. The first fetch state follows.
- R7: Every other opcode value makes the cycle after decode the first fetch state.
- R8: At most one of gate_pc, gate_alu, gate_marmux and gate_mdr is high in any cycle.
- R9: mem_we is never high without mem_en.
- R10: ir_opcode is ignored in every state but decode. Changing it outside decode does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_opcode | input | 4 | Top four bits of the instruction register |
| mem_ready | input | 1 | Memory has completed the current access |
| gate_pc | output | 1 | PC drives the bus |
| gate_alu | output | 1 | ALU result drives the bus |
| gate_marmux | output | 1 | Address adder drives the bus |
| gate_mdr | output | 1 | Memory data register drives the bus |
| ld_mar | output | 1 | Memory address register loads |
| ld_mdr | output | 1 | Memory data register loads |
| ld_ir | output | 1 | Instruction register loads |
| ld_pc | output | 1 | PC loads the PC mux output |
| ld_reg | output | 1 | Register file writes the destination |
| ld_cc | output | 1 | Condition codes load from the bus |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| pc_sel | output | 2 | PC mux select, 2'b00 = incremented PC |
| marmux_base | output | 1 | Address adder uses base register plus 6-bit offset |
| alu_pass | output | 1 | ALU passes its first operand unchanged instead of adding |
| sr1_from_src | output | 1 | First register read port takes the store-source field |

## Verification
Two things can coincide in a single cycle. One is a memory state that is stalled or released by mem_ready. The other is the load strobe that this same ready input drives directly, since ld_mdr follows ready in the read states. The bench sweeps every opcode against stalls of zero to three cycles. It drops and raises mem_ready exactly on the cycles it models as stall or release, and checks the complete strobe vector each cycle, so that a stalled state never loads the MDR and the release cycle both loads and advances. In the same sweep the opcode input is scrambled outside decode, which tests that it is sampled only in the decode cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int unsigned PCSEL_W = 2;
  localparam logic [PCSEL_W-1:0] PCSEL_INC = '0;

  typedef enum logic [3:0] {
    ST_F_PC,
    ST_F_MEM,
    ST_F_IR,
    ST_DEC,
    ST_ADD,
    ST_LD_ADDR,
    ST_LD_MEM,
    ST_LD_WB,
    ST_ST_ADDR,
    ST_ST_DATA,
    ST_ST_MEM
  } seq_state_e;

  typedef struct packed {
    logic               gate_pc;
    logic               gate_alu;
    logic               gate_marmux;
    logic               gate_mdr;
    logic               ld_mar;
    logic               ld_mdr;
    logic               ld_ir;
    logic               ld_pc;
    logic               ld_reg;
    logic               ld_cc;
    logic               mem_en;
    logic               mem_we;
    logic [PCSEL_W-1:0] pc_sel;
    logic               marmux_base;
    logic               alu_pass;
    logic               sr1_from_src;
  } ctrl_word_t;

endpackage

// File: rtl/mcs_rst_sync.sv
module mcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
#(
  parameter int unsigned       OPC_W   = 4,
  parameter logic [OPC_W-1:0]  OPC_ADD = 4'b0001,
  parameter logic [OPC_W-1:0]  OPC_LDR = 4'b0110,
  parameter logic [OPC_W-1:0]  OPC_STR = 4'b0111
) (
  input  seq_state_e       state,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_ready,
  output seq_state_e       state_nxt
);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_F_PC:    state_nxt = ST_F_MEM;
      ST_F_MEM:   if (mem_ready) state_nxt = ST_F_IR;
      ST_F_IR:    state_nxt = ST_DEC;
      ST_DEC: begin
        if      (opcode == OPC_ADD) state_nxt = ST_ADD;
        else if (opcode == OPC_LDR) state_nxt = ST_LD_ADDR;
        else if (opcode == OPC_STR) state_nxt = ST_ST_ADDR;
        else                        state_nxt = ST_F_PC;
      end
      ST_ADD:     state_nxt = ST_F_PC;
      ST_LD_ADDR: state_nxt = ST_LD_MEM;
      ST_LD_MEM:  if (mem_ready) state_nxt = ST_LD_WB;
      ST_LD_WB:   state_nxt = ST_F_PC;
      ST_ST_ADDR: state_nxt = ST_ST_DATA;
      ST_ST_DATA: state_nxt = ST_ST_MEM;
      ST_ST_MEM:  if (mem_ready) state_nxt = ST_F_PC;
      default:    state_nxt = ST_F_PC;
    endcase
  end

endmodule

// File: rtl/mcs_strobe_dec.sv
module mcs_strobe_dec
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n_sync,
  input  seq_state_e state,
  input  logic       mem_ready,
  output ctrl_word_t cw
);

  always_comb begin
    cw        = '0;
    cw.pc_sel = PCSEL_INC;
    unique case (state)
      ST_F_PC: begin
        cw.gate_pc = 1'b1;
        cw.ld_mar  = 1'b1;
        cw.ld_pc   = 1'b1;
      end
      ST_F_MEM, ST_LD_MEM: begin
        cw.mem_en = 1'b1;
        cw.ld_mdr = mem_ready;
      end
      ST_F_IR: begin
        cw.gate_mdr = 1'b1;
        cw.ld_ir    = 1'b1;
      end
      ST_DEC: ;
      ST_ADD: begin
        cw.gate_alu = 1'b1;
        cw.ld_reg   = 1'b1;
        cw.ld_cc    = 1'b1;
      end
      ST_LD_ADDR, ST_ST_ADDR: begin
        cw.gate_marmux = 1'b1;
        cw.ld_mar      = 1'b1;
        cw.marmux_base = 1'b1;
      end
      ST_LD_WB: begin
        cw.gate_mdr = 1'b1;
        cw.ld_reg   = 1'b1;
        cw.ld_cc    = 1'b1;
      end
      ST_ST_DATA: begin
        cw.gate_alu     = 1'b1;
        cw.ld_mdr       = 1'b1;
        cw.alu_pass     = 1'b1;
        cw.sr1_from_src = 1'b1;
      end
      ST_ST_MEM: begin
        cw.mem_en = 1'b1;
        cw.mem_we = 1'b1;
      end
      default: ;
    endcase
  end

  // R8
  single_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones({cw.gate_pc, cw.gate_alu, cw.gate_marmux, cw.gate_mdr}) <= 1);

  // R9
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cw.mem_we |-> cw.mem_en);

  // R8
  bus_load_has_driver_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cw.ld_ir || cw.ld_reg || cw.ld_mar) |->
      $onehot0({cw.gate_pc, cw.gate_alu, cw.gate_marmux, cw.gate_mdr}) &&
      (cw.gate_pc || cw.gate_alu || cw.gate_marmux || cw.gate_mdr));

endmodule

// File: rtl/mcs_ctrl_top.sv
module mcs_ctrl_top
  import mcs_pkg::*;
#(
  parameter int unsigned      OPC_W      = 4,
  parameter int unsigned      RST_STAGES = 2,
  parameter logic [OPC_W-1:0] OPC_ADD    = 4'b0001,
  parameter logic [OPC_W-1:0] OPC_LDR    = 4'b0110,
  parameter logic [OPC_W-1:0] OPC_STR    = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   ir_opcode,
  input  logic               mem_ready,
  output logic               gate_pc,
  output logic               gate_alu,
  output logic               gate_marmux,
  output logic               gate_mdr,
  output logic               ld_mar,
  output logic               ld_mdr,
  output logic               ld_ir,
  output logic               ld_pc,
  output logic               ld_reg,
  output logic               ld_cc,
  output logic               mem_en,
  output logic               mem_we,
  output logic [PCSEL_W-1:0] pc_sel,
  output logic               marmux_base,
  output logic               alu_pass,
  output logic               sr1_from_src
);

  logic       rst_n_sync;
  seq_state_e state_q;
  seq_state_e state_nxt;
  ctrl_word_t cw;
  logic       state_en;

  mcs_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mcs_next_state #(
    .OPC_W   (OPC_W),
    .OPC_ADD (OPC_ADD),
    .OPC_LDR (OPC_LDR),
    .OPC_STR (OPC_STR)
  ) next_i (
    .state     (state_q),
    .opcode    (ir_opcode),
    .mem_ready (mem_ready),
    .state_nxt (state_nxt)
  );

  assign state_en = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)   state_q <= ST_F_PC;
    else if (state_en) state_q <= state_nxt;
  end

  mcs_strobe_dec dec_i (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .state      (state_q),
    .mem_ready  (mem_ready),
    .cw         (cw)
  );

  assign gate_pc      = cw.gate_pc;
  assign gate_alu     = cw.gate_alu;
  assign gate_marmux  = cw.gate_marmux;
  assign gate_mdr     = cw.gate_mdr;
  assign ld_mar       = cw.ld_mar;
  assign ld_mdr       = cw.ld_mdr;
  assign ld_ir        = cw.ld_ir;
  assign ld_pc        = cw.ld_pc;
  assign ld_reg       = cw.ld_reg;
  assign ld_cc        = cw.ld_cc;
  assign mem_en       = cw.mem_en;
  assign mem_we       = cw.mem_we;
  assign pc_sel       = cw.pc_sel;
  assign marmux_base  = cw.marmux_base;
  assign alu_pass     = cw.alu_pass;
  assign sr1_from_src = cw.sr1_from_src;

  // R2
  mem_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_en && !mem_ready) |=> (mem_en && $stable(mem_we)));

  // R3
  ir_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ld_ir |=> !(gate_pc || gate_alu || gate_marmux || gate_mdr || ld_mar ||
                ld_mdr || ld_ir || ld_pc || ld_reg || ld_cc || mem_en));

  // R4
  add_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (gate_alu && ld_reg) |=> (gate_pc && ld_pc && ld_mar));

  // R6
  str_order_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q == ST_ST_ADDR) |=> (state_q == ST_ST_DATA));

  // R1
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    gate_pc |=> (mem_en && !mem_we));

endmodule

// File: tb/mcs_ctrl_top_tb_top.sv
module mcs_ctrl_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ir_opcode;
  logic       mem_ready;
  logic       gate_pc, gate_alu, gate_marmux, gate_mdr;
  logic       ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc;
  logic       mem_en, mem_we, marmux_base, alu_pass, sr1_from_src;
  logic [1:0] pc_sel;

  int tests_run = 0;
  int tests_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcs_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .mem_ready(mem_ready),
    .gate_pc(gate_pc), .gate_alu(gate_alu), .gate_marmux(gate_marmux),
    .gate_mdr(gate_mdr), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
    .ld_pc(ld_pc), .ld_reg(ld_reg), .ld_cc(ld_cc), .mem_en(mem_en),
    .mem_we(mem_we), .pc_sel(pc_sel), .marmux_base(marmux_base),
    .alu_pass(alu_pass), .sr1_from_src(sr1_from_src)
  );

  // vector: gpc galu gmar gmdr lmar lmdr lir lpc lreg lcc men mwe pcsel[1:0] mbase apass srcsel
  function automatic logic [16:0] vec(input bit gpc, galu, gmar, gmdr, lmar, lmdr,
                                      lir, lpc, lreg, lcc, men, mwe, mbase, apass, srcsel);
    return {gpc, galu, gmar, gmdr, lmar, lmdr, lir, lpc, lreg, lcc, men, mwe,
            2'b00, mbase, apass, srcsel};
  endfunction

  function automatic logic [16:0] actual();
    return {gate_pc, gate_alu, gate_marmux, gate_mdr, ld_mar, ld_mdr, ld_ir, ld_pc,
            ld_reg, ld_cc, mem_en, mem_we, pc_sel, marmux_base, alu_pass, sr1_from_src};
  endfunction

  function automatic logic [16:0] v_fpc();        return vec(1,0,0,0,1,0,0,1,0,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_rd(bit r);    return vec(0,0,0,0,0,r,0,0,0,0,1,0,0,0,0); endfunction
  function automatic logic [16:0] v_fir();        return vec(0,0,0,1,0,0,1,0,0,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_idle();       return '0; endfunction
  function automatic logic [16:0] v_add();        return vec(0,1,0,0,0,0,0,0,1,1,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_addr();       return vec(0,0,1,0,1,0,0,0,0,0,0,0,1,0,0); endfunction
  function automatic logic [16:0] v_ldwb();       return vec(0,0,0,1,0,0,0,0,1,1,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_stdata();     return vec(0,1,0,0,0,1,0,0,0,0,0,0,0,1,1); endfunction
  function automatic logic [16:0] v_wr();         return vec(0,0,0,0,0,0,0,0,0,0,1,1,0,0,0); endfunction

  task automatic step(input logic [16:0] exp, input bit rdy, input logic [3:0] opc,
                      input string req);
    @(negedge clk);
    mem_ready = rdy;
    ir_opcode = opc;
    #1;
    tests_run++;
    if (actual() !== exp) begin
      tests_fail++;
      $display("FAIL %s: strobes actual=%b expected=%b (opcode %h ready %0d)",
               req, actual(), exp, opc, rdy);
    end
  endtask

  // memory read state with w stall cycles
  task automatic read_state(input int w, input logic [3:0] junk, input string req);
    for (int i = 0; i < w; i++) step(v_rd(0), 0, junk ^ 4'(i), req);
    step(v_rd(1), 1, junk, req);
  endtask

  task automatic run_instr(input logic [3:0] opc, input int w);
    logic [3:0] junk;
    junk = opc ^ 4'b0111;   // R10: a different opcode outside decode
    step(v_fpc(), 0, junk, "R1");
    read_state(w, junk, "R2");
    step(v_fir(), 0, junk ^ 4'b0110, "R3");
    step(v_idle(), 0, opc, "R3");
    case (opc)
      4'b0001: step(v_add(), 0, junk, "R4");
      4'b0110: begin
        step(v_addr(), 0, junk, "R5");
        read_state(w, junk, "R5");
        step(v_ldwb(), 0, junk, "R5");
      end
      4'b0111: begin
        step(v_addr(), 0, junk, "R6");
        step(v_stdata(), 0, junk, "R6");
        for (int i = 0; i < w; i++) step(v_wr(), 0, junk, "R6");
        step(v_wr(), 1, junk, "R6");
      end
      default: ;  // R7: next cycle must be first fetch, checked by the next run
    endcase
  endtask

  initial begin
    rst_n = 1'b0;
    mem_ready = 1'b0;
    ir_opcode = 4'b0001;
    #23;
    // R1: outputs during reset
    tests_run++;
    if (actual() !== v_fpc()) begin
      tests_fail++;
      $display("FAIL R1: in reset actual=%b expected=%b", actual(), v_fpc());
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tests_run++;
    if (actual() !== v_fpc()) begin
      tests_fail++;
      $display("FAIL R1: at release actual=%b expected=%b", actual(), v_fpc());
    end
    step(v_fpc(), 1, 4'b0001, "R1");  // R1: still held by synchronizer
    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 16; op++)
        run_instr(4'(op), w);
    // R7/R4: closing fetch after the last instruction
    step(v_fpc(), 0, 4'b0000, "R7");
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule